// File: doc/BRIEF.md
# Programmable Timer Counter Channel

This block is one timer/counter channel with a small word-addressed register port. A count enable is derived either from every cycle of the system clock or from a selected edge of an external clock pin, and an optional power-of-two prescaler divides it further. The counter moves up or down. In free-running mode it uses the whole counter range. In interval mode it is bounded by a programmable limit.

Three compare registers watch the count. Events are collected in a status register that clears when read. The interrupt line is active whenever an enabled status bit is set. A waveform output changes level on the first compare and returns on each wrap, with software-selectable polarity. Software programs a one-shot delay by writing a compare value equal to the current count plus the delay, taken modulo the counter range. Periodic operation uses interval mode.

Top module: `tmr_channel`

## Requirements
- R1: After reset, every register reads back as follows. Clock control reads 0. Counter control reads 0x21: stopped, waveform disabled. The count reads 0 and the limit reads all ones. Compare registers, status and enable read 0. `irq_o` and `wave_o` are low.
- R2: Clock control has the following fields. Bit 0 enables the prescaler and bits 4:1 hold N. With the prescaler off, the count moves once per source pulse. With it on, the count moves once per 2^(N+1) source pulses.
- R3: Clock control bit 5 chooses the external pin as the pulse source, and bit 6 then selects its falling edge instead of its rising edge. Each selected edge of the pin, after a two-flop synchronizer, gives exactly one source pulse. The other edge gives none.
- R4: Counter control bit 0 stops the channel. While it is set the count holds its value, and clearing it resumes counting from that value.
- R5: Writing counter control with bit 4 set zeroes the count, the prescaler and the waveform state in the cycle of the write. Bit 4 is not stored and reads back 0.
- R6: Counter control bit 2 selects down counting, and bit 1 = 0 selects free-running mode. In free-running mode an up count wraps from all ones to 0 and a down count wraps from 0 to all ones. Each wrap sets status bit 4.
- R7: In interval mode (counter control bit 1 = 1), an up count goes from 0 to the limit and then to 0. A down count goes to 0 and then reloads the limit. Each such wrap sets status bit 0.
- R8: Counter control bit 3 enables matching. When enabled, a count step that lands on compare register i (i = 0, 1, 2) sets status bit 1+i. A compare value below the current count is reached after the count wraps. With matching disabled, no compare bit is set.
- R9: A read of the status register returns its bits and clears them. A status bit that is raised in the same cycle as the read stays set for the next read.
- R10: `irq_o` is high exactly when some status bit is set whose enable bit is also set. The enable register holds bits 4:0 in the status layout.
- R11: Counter control bit 5 = 0 enables the waveform. With bit 6 = 1 the waveform idles high, falls on a compare-0 hit and rises on a wrap. With bit 6 = 0 the levels are inverted. When the waveform is disabled, `wave_o` is 0.
- R12: The register word addresses are: 0 clock control, 1 counter control, 2 count (read only), 3 limit, 4 to 6 compare 0 to 2, 7 status (read only), 8 enable. Writes to the read-only words are ignored, and unused addresses read 0.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, clears status when addressing it |
| addr_i | input | AW | Register word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| wave_o | output | 1 | Waveform output |

## Verification
A wrong prescaler phase or a stale synchronizer flop shows up as a count read that is short or long by one step. It appears within a single period of 2^(N+1) pulses. A wrong wrap bound or reload value shows in the count read right after the limit is crossed, and as a missing or extra status bit 0 or 4 on the next status read. The cases with the most risk are a status event that arrives in the same cycle as its clearing read and a compare target reached only after a full wrap. A stuck waveform state shows on `wave_o` within two steps of the compare hit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PDIV_W = 4;
  localparam int DIV_W  = (1 << PDIV_W) + 1;
  localparam int IRQ_W  = 5;
  localparam int NMATCH = 3;

  localparam int BIT_INTV  = 0;
  localparam int BIT_MATCH = 1;
  localparam int BIT_OVF   = 4;

  localparam logic [3:0] A_CLK   = 4'd0;
  localparam logic [3:0] A_CTRL  = 4'd1;
  localparam logic [3:0] A_COUNT = 4'd2;
  localparam logic [3:0] A_LIMIT = 4'd3;
  localparam logic [3:0] A_CMP0  = 4'd4;
  localparam logic [3:0] A_STAT  = 4'd7;
  localparam logic [3:0] A_EN    = 4'd8;

  typedef struct packed {
    logic              fall_edge;
    logic              ext_src;
    logic [PDIV_W-1:0] pdiv;
    logic              pre_on;
  } clk_cfg_t;

  typedef struct packed {
    logic pol;
    logic wave_off;
    logic zero;
    logic match_on;
    logic down;
    logic intv_mode;
    logic stop;
  } cnt_cfg_t;

  localparam cnt_cfg_t CNT_CFG_RST = 7'h21;

  function automatic logic [DIV_W-1:0] presc_limit(input logic [PDIV_W-1:0] n);
    return (DIV_W'(2) << n) - DIV_W'(1);
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_clk_i,
  input  clk_cfg_t cfg_i,
  input  logic     run_i,
  input  logic     restart_i,
  output logic     ext_edge_o,
  output logic     tick_o
);

  logic sync1_q, sync2_q, sync3_q;
  logic rise_w, fall_w, src_w, at_limit_w;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      sync3_q <= 1'b0;
    end else begin
      sync1_q <= ext_clk_i;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  assign rise_w     = sync2_q & ~sync3_q;
  assign fall_w     = ~sync2_q & sync3_q;
  assign ext_edge_o = cfg_i.fall_edge ? fall_w : rise_w;
  assign src_w      = cfg_i.ext_src ? ext_edge_o : 1'b1;

  assign limit_w    = presc_limit(cfg_i.pdiv);
  assign at_limit_w = (div_q >= limit_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
    end else if (run_i && src_w && cfg_i.pre_on) begin
      div_q <= at_limit_w ? '0 : div_q + DIV_W'(1);
    end
  end

  assign tick_o = run_i & src_w & (~cfg_i.pre_on | at_limit_w);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge_o |=> (!ext_edge_o || cfg_i.fall_edge != $past(cfg_i.fall_edge))) // R3
    else $error("edge pulse longer than one cycle");

  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cfg_i.pre_on) |=> (!tick_o || !cfg_i.pre_on)) // R2
    else $error("prescaled ticks back to back");

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int NM = NMATCH
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   restart_i,
  input  cnt_cfg_t               ctrl_i,
  input  logic [CW-1:0]          limit_i,
  input  logic [NM-1:0][CW-1:0]  cmp_i,
  output logic [CW-1:0]          count_o,
  output logic                   wrap_ovf_o,
  output logic                   wrap_intv_o,
  output logic [NM-1:0]          hit_o,
  output logic                   wave_o
);

  function automatic logic [CW:0] step_value(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] lim,
                                             input logic dn,
                                             input logic bounded);
    logic          wr;
    logic [CW-1:0] nx;
    wr = 1'b0;
    nx = cur;
    if (!dn) begin
      if (bounded ? (cur >= lim) : (cur == {CW{1'b1}})) begin
        wr = 1'b1;
        nx = '0;
      end else begin
        nx = cur + CW'(1);
      end
    end else if (cur == '0) begin
      wr = 1'b1;
      nx = bounded ? lim : {CW{1'b1}};
    end else begin
      nx = cur - CW'(1);
    end
    return {wr, nx};
  endfunction

  logic [CW-1:0] count_q;
  logic [CW-1:0] next_w;
  logic          wrap_w, step_w;
  logic          wave_act_q;

  assign step_w           = tick_i & ~restart_i;
  assign {wrap_w, next_w} = step_value(count_q, limit_i, ctrl_i.down, ctrl_i.intv_mode);
  assign wrap_ovf_o       = step_w & wrap_w & ~ctrl_i.intv_mode;
  assign wrap_intv_o      = step_w & wrap_w & ctrl_i.intv_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (restart_i) count_q <= '0;
    else if (step_w)    count_q <= next_w;
  end

  for (genvar gi = 0; gi < NM; gi++) begin : g_cmp
    assign hit_o[gi] = step_w & ctrl_i.match_on & (next_w == cmp_i[gi]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wave_act_q <= 1'b0;
    else if (restart_i)               wave_act_q <= 1'b0;
    else if (hit_o[0])                wave_act_q <= 1'b1;
    else if (wrap_ovf_o || wrap_intv_o) wave_act_q <= 1'b0;
  end

  assign wave_o  = ~ctrl_i.wave_off & (wave_act_q ^ ctrl_i.pol);
  assign count_o = count_q;

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.stop && !restart_i) |=> $stable(count_q)) // R4
    else $error("count moved while stopped");

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_q == '0)) // R5
    else $error("restart did not zero count");

  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ovf_o && !ctrl_i.down) |=> (count_q == '0)) // R6
    else $error("up wrap did not land on zero");

  AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.intv_mode && !ctrl_i.down && count_q <= limit_i) |=> (count_q <= $past(limit_i))) // R7
    else $error("interval count escaped the limit");

endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             rd_clr_i,
  input  logic [IRQ_W-1:0] en_i,
  output logic [IRQ_W-1:0] status_o,
  output logic             irq_o
);

  logic [IRQ_W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_clr_i ? '0 : status_q) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && set_i == '0) |=> (status_o == '0)) // R9
    else $error("status not cleared by read");

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o))) // R9
    else $error("status bit lost without read");

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))) // R9
    else $error("raised status bit dropped");

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wave_o
);

  localparam int CFG_W = $bits(cnt_cfg_t);

  clk_cfg_t                    clk_cfg_q;
  cnt_cfg_t                    cnt_cfg_q;
  logic [CW-1:0]               limit_q;
  logic [NMATCH-1:0][CW-1:0]   cmp_q;
  logic [IRQ_W-1:0]            irq_en_q;

  logic                        restart_w, rd_clr_w, tick_w, ext_edge_w;
  logic [CW-1:0]               count_w;
  logic                        wrap_ovf_w, wrap_intv_w;
  logic [NMATCH-1:0]           hit_w;
  logic [IRQ_W-1:0]            set_w, status_w;
  logic [AW-1:0]               cmp_base_w;

  assign cmp_base_w = AW'(A_CMP0);
  assign restart_w  = wr_en_i && (addr_i == AW'(A_CTRL)) && wdata_i[4];
  assign rd_clr_w   = rd_en_i && (addr_i == AW'(A_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg_q <= '0;
      cnt_cfg_q <= CNT_CFG_RST;
      limit_q   <= '1;
      cmp_q     <= '0;
      irq_en_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == AW'(A_CLK))   clk_cfg_q <= clk_cfg_t'(wdata_i[$bits(clk_cfg_t)-1:0]);
      if (addr_i == AW'(A_CTRL))  cnt_cfg_q <= cnt_cfg_t'({wdata_i[6:5], 1'b0, wdata_i[3:0]});
      if (addr_i == AW'(A_LIMIT)) limit_q   <= wdata_i[CW-1:0];
      if (addr_i == AW'(A_EN))    irq_en_q  <= wdata_i[IRQ_W-1:0];
      for (int k = 0; k < NMATCH; k++) begin
        if (addr_i == cmp_base_w + AW'(k)) cmp_q[k] <= wdata_i[CW-1:0];
      end
    end
  end

  tmr_tick_gen u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk_i  (ext_clk_i),
    .cfg_i      (clk_cfg_q),
    .run_i      (~cnt_cfg_q.stop),
    .restart_i  (restart_w),
    .ext_edge_o (ext_edge_w),
    .tick_o     (tick_w)
  );

  tmr_count_core #(.CW(CW), .NM(NMATCH)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_w),
    .restart_i   (restart_w),
    .ctrl_i      (cnt_cfg_q),
    .limit_i     (limit_q),
    .cmp_i       (cmp_q),
    .count_o     (count_w),
    .wrap_ovf_o  (wrap_ovf_w),
    .wrap_intv_o (wrap_intv_w),
    .hit_o       (hit_w),
    .wave_o      (wave_o)
  );

  always_comb begin
    set_w                                 = '0;
    set_w[BIT_INTV]                       = wrap_intv_w;
    set_w[BIT_MATCH +: NMATCH]            = hit_w;
    set_w[BIT_OVF]                        = wrap_ovf_w;
  end

  tmr_irq_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_w),
    .rd_clr_i (rd_clr_w),
    .en_i     (irq_en_q),
    .status_o (status_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(A_CLK):   rdata_o = DW'(clk_cfg_q);
      AW'(A_CTRL):  rdata_o = DW'(cnt_cfg_q);
      AW'(A_COUNT): rdata_o = DW'(count_w);
      AW'(A_LIMIT): rdata_o = DW'(limit_q);
      AW'(A_STAT):  rdata_o = DW'(status_w);
      AW'(A_EN):    rdata_o = DW'(irq_en_q);
      default: begin
        for (int k = 0; k < NMATCH; k++) begin
          if (addr_i == cmp_base_w + AW'(k)) rdata_o = DW'(cmp_q[k]);
        end
      end
    endcase
  end

  AST_CTRL_NO_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (cnt_cfg_q[4] == 1'b0 && CFG_W == 7)) // R5
    else $error("self-clearing bit stored");

  AST_EDGE_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && clk_cfg_q.ext_src && !clk_cfg_q.pre_on) |-> ext_edge_w) // R3
    else $error("tick without external edge");

endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, wave_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .wave_o(wave_o)
  );

  // clk ctrl[61:55] cnt ctrl[54:48] limit[47:32] wait[31:16] expected count[15:0]
  localparam logic [61:0] VECS [7] = '{
    {7'h00, 7'h30, 16'hFFFF, 16'd10, 16'd10},
    {7'h01, 7'h30, 16'hFFFF, 16'd10, 16'd5},
    {7'h05, 7'h30, 16'hFFFF, 16'd30, 16'd3},
    {7'h07, 7'h30, 16'hFFFF, 16'd50, 16'd3},
    {7'h00, 7'h34, 16'hFFFF, 16'd3,  16'hFFFD},
    {7'h00, 7'h32, 16'h0004, 16'd12, 16'd2},
    {7'h00, 7'h36, 16'h0004, 16'd7,  16'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, c1;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 / R12 reset state and map
    rd(4'd0, v); check("R1 clk ctrl", v, 32'h0);
    rd(4'd1, v); check("R1 cnt ctrl", v, 32'h21);
    rd(4'd2, v); check("R1 count", v, 32'h0);
    rd(4'd3, v); check("R1 limit", v, 32'hFFFF);
    rd(4'd7, v); check("R1 status", v, 32'h0);
    rd(4'd8, v); check("R1 enable", v, 32'h0);
    rd(4'd9, v); check("R12 unused addr", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 wave", {31'b0, wave_o}, 32'h0);

    wr(4'd2, 32'h1234);
    rd(4'd2, v); check("R12 count write ignored", v, 32'h0);

    // R2 / R6 / R7 vector table
    for (int i = 0; i < 7; i++) begin
      wr(4'd0, 32'(VECS[i][61:55]));
      wr(4'd3, 32'(VECS[i][47:32]));
      wr(4'd1, 32'(VECS[i][54:48]));
      idle(int'(VECS[i][31:16]));
      rd(4'd2, v);
      check(i < 4 ? "R2 vector count" : (i == 4 ? "R6 down vector count" : "R7 interval vector count"),
            v, 32'(VECS[i][15:0]));
    end
    wr(4'd0, 32'h0);

    // R4 stop and resume
    wr(4'd1, 32'h30);
    idle(5);
    wr(4'd1, 32'h21);
    rd(4'd2, c1);
    idle(5);
    rd(4'd2, v); check("R4 held while stopped", v, c1);
    wr(4'd1, 32'h20);
    idle(4);
    rd(4'd2, v); check("R4 resumes from held value", v, c1 + 32'd4);

    // R5 restart
    wr(4'd1, 32'h31);
    rd(4'd2, v); check("R5 restart zeroes count", v, 32'h0);
    rd(4'd1, v); check("R5 restart bit reads 0", v, 32'h21);

    // R7 / R8 / R9 interval with matching, same-cycle event on read
    wr(4'd4, 32'h10); wr(4'd5, 32'h2); wr(4'd6, 32'h3); wr(4'd3, 32'h4);
    wr(4'd1, 32'h3B);
    rd(4'd7, v);
    wr(4'd1, 32'h2A);
    idle(4);
    rd(4'd7, v); check("R8 compare 1 and 2 bits", v, 32'h0C);
    rd(4'd7, v); check("R9 wrap during read kept, R7 bit", v, 32'h01);

    // R8 matching disabled
    wr(4'd1, 32'h33);
    rd(4'd7, v);
    wr(4'd1, 32'h22);
    idle(6);
    rd(4'd7, v); check("R8 no compare bits when disabled", v, 32'h01);

    // R3 external clock edges
    wr(4'd0, 32'h60);
    wr(4'd1, 32'h30);
    ext_clk_i = 1'b1; idle(4);
    rd(4'd2, v); check("R3 rising ignored on falling select", v, 32'h0);
    ext_clk_i = 1'b0; idle(4);
    rd(4'd2, v); check("R3 falling counted", v, 32'h1);
    wr(4'd0, 32'h20);
    wr(4'd1, 32'h30);
    ext_clk_i = 1'b1; idle(4);
    rd(4'd2, v); check("R3 rising counted", v, 32'h1);
    ext_clk_i = 1'b0; idle(4);
    rd(4'd2, v); check("R3 falling ignored on rising select", v, 32'h1);
    wr(4'd0, 32'h0);

    // R11 waveform
    wr(4'd4, 32'h2); wr(4'd3, 32'h5);
    wr(4'd1, 32'h5B);
    check("R11 high polarity idle", {31'b0, wave_o}, 32'h1);
    wr(4'd1, 32'h4A);
    idle(2);
    check("R11 high polarity falls on compare 0", {31'b0, wave_o}, 32'h0);
    idle(4);
    check("R11 high polarity rises on wrap", {31'b0, wave_o}, 32'h1);
    wr(4'd1, 32'h1B);
    check("R11 low polarity idle", {31'b0, wave_o}, 32'h0);
    wr(4'd1, 32'h0A);
    idle(2);
    check("R11 low polarity rises on compare 0", {31'b0, wave_o}, 32'h1);
    wr(4'd1, 32'h3B);
    wr(4'd1, 32'h2A);
    idle(2);
    check("R11 disabled output low", {31'b0, wave_o}, 32'h0);

    // R6 / R8 / R10 full wrap with compare target past the wrap
    wr(4'd4, 32'h10); wr(4'd5, 32'h8000); wr(4'd6, 32'h8000);
    wr(4'd8, 32'h02);
    wr(4'd1, 32'h38);
    idle(32'hFFF0);
    rd(4'd2, v); check("R2 long run count", v, 32'hFFF0);
    rd(4'd7, v);
    idle(32'h30);
    check("R10 irq with enabled compare 0", {31'b0, irq_o}, 32'h1);
    wr(4'd8, 32'h01);
    check("R10 irq masked", {31'b0, irq_o}, 32'h0);
    rd(4'd7, v); check("R6 overflow and R8 wrapped compare", v, 32'h12);
    rd(4'd7, v); check("R9 cleared after read", v, 32'h0);

    finish_run();
  end
endmodule